// File: doc/BRIEF.md
# Framebuffer Clear and Sprite Blitter

This block is the pixel sequencer behind a small 64x32 monochrome display for an 8-bit interpreter-style processor. It serves two commands. A clear command zeroes the whole screen one pixel per cycle. A draw command XORs a sprite onto the screen at a given origin. The sprite is 8 pixels wide and up to 15 rows tall, and its row bytes come from main memory. The framebuffer is an external memory with one bit per address. It has a 6-bit X and a 5-bit Y coordinate and a one-cycle synchronous read. Main memory is an external byte-wide store with a 12-bit address and the same one-cycle read latency.

Each sprite pixel needs two cycles: a read of the old screen bit, then a write of that bit XOR the sprite bit. The row byte is fetched one cycle before the row's first pixel read. When any lit pixel is turned dark, a collision flag is raised. The processor copies this flag into its flag register. The processor starts a command with a one-cycle request while the block is idle. It then waits for the one-cycle completion pulse.

Top module: `fb_blit_engine`

## Requirements
- R1: After reset, `busy`, `done` and `hit` are low. Whenever `busy` is low, `fb_we`, `fb_rd` and `mem_rd` are all low.
- R2: A clear writes `fb_wdata`=0 once to every one of the 2048 pixels, one write per cycle. Y is the inner count and X the outer, so the write with index k goes to x=k/32, y=k%32, running from (0,0) to (63,31).
- R3: A clear holds `busy` for exactly 2048 cycles. `done` is high for one cycle, in the cycle after the last write, and `busy` is low in that cycle.
- R4: A draw with origin (X,Y), row count N and base address B fetches row r from memory address (B+r) mod 4096. Bit 7 of the byte is the leftmost pixel, and byte bit 7-b maps to column b. That bit is XORed into pixel ((X+b) mod 64, (Y+r) mod 32).
- R5: For each sprite pixel, a framebuffer read cycle is followed in the next cycle by a write to the same address. Each row spends one cycle on its memory fetch and then 16 cycles on pixels. A draw therefore holds `busy` for 17*N cycles, and `done` follows in the next cycle.
- R6: `hit` clears when a draw is accepted. It is set if any pixel that read as 1 is written as 0. It holds its value until the next draw is accepted, and a clear does not change it.
- R7: A draw with N=0 touches neither the framebuffer nor memory. It gives `done` in the cycle after acceptance and clears `hit`.
- R8: Requests that arrive while `busy` is high are ignored. The running command finishes with its own timing and pixel result.
- R9: When `clr_req` and `drw_req` are both high in an idle cycle, the clear is performed and the draw is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr_req | input | 1 | Start a screen clear (taken only while idle) |
| drw_req | input | 1 | Start a sprite draw (taken only while idle) |
| drw_x | input | 6 | Sprite origin column |
| drw_y | input | 5 | Sprite origin row |
| drw_rows | input | 4 | Sprite height in rows |
| drw_base | input | 12 | Memory address of the first sprite row |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Collision flag of the most recent draw |
| mem_addr | output | 12 | Main-memory read address |
| mem_rd | output | 1 | Main-memory read strobe |
| mem_data | input | 8 | Main-memory read data, one cycle after `mem_rd` |
| fb_x | output | 6 | Framebuffer column address |
| fb_y | output | 5 | Framebuffer row address |
| fb_rd | output | 1 | Framebuffer read strobe |
| fb_we | output | 1 | Framebuffer write enable |
| fb_wdata | output | 1 | Framebuffer write data |
| fb_rdata | input | 1 | Framebuffer read data, one cycle after `fb_rd` |

## Verification
A fault in the clear scan counter shows up at once: a write lands out of order, and the address sequence check catches it on the first wrong pixel. The completion cycle also moves away from 2049. A fault in the sprite row or bit counters puts pixels in the wrong place or shifts the number of draw cycles. The full-screen compare after each draw reports it, along with the 17N+1 timing check. A row byte captured at the wrong cycle, or a collision flag that drops or sticks, only becomes visible when the command finishes. The bench compares `hit` and the whole screen against its own model at that point.

// File: rtl/fbb_pkg.sv
// Shared types for the framebuffer clear / sprite blitter.
// Assumes: a single sequencer state machine in fb_blit_engine.
package fbb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLR,
        ST_FETCH,
        ST_READ,
        ST_WRITE,
        ST_DONE
    } fbb_state_e;

endpackage

// File: rtl/fbb_clear_scan.sv
// Clear sweep counter: steps through every framebuffer address with Y as
// the inner (fast) count and X as the outer count.
// Assumes: start and step are never high together; start resets to (0,0).
module fbb_clear_scan #(
    parameter int XW = 6,
    parameter int YW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          step,
    output logic [XW-1:0] scan_x,
    output logic [YW-1:0] scan_y,
    output logic          last
);
    localparam int CW = XW + YW;

    logic [CW-1:0] cnt_q;

    // Sweep position: reset/start to zero, advance by one per step.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign scan_y = cnt_q[YW-1:0];
    assign scan_x = cnt_q[CW-1:YW];
    assign last   = &cnt_q;

endmodule

// File: rtl/fbb_sprite_walk.sv
// Sprite walker: latches a draw's origin, base address and height, then
// tracks the current row and bit to produce the wrapped pixel coordinate
// and the memory address of the current row.
// Assumes: adv is pulsed once per written pixel; coordinates wrap naturally
// at the XW/YW widths and the address wraps at AW bits.
module fbb_sprite_walk #(
    parameter int XW = 6,
    parameter int YW = 5,
    parameter int AW = 12,
    parameter int NW = 4,
    parameter int DW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   adv,
    input  logic [XW-1:0]          org_x,
    input  logic [YW-1:0]          org_y,
    input  logic [AW-1:0]          base,
    input  logic [NW-1:0]          rows,
    output logic [XW-1:0]          px_x,
    output logic [YW-1:0]          px_y,
    output logic [AW-1:0]          row_addr,
    output logic [$clog2(DW)-1:0]  bit_idx,
    output logic                   bit_last,
    output logic                   row_last
);
    localparam int BW = $clog2(DW);

    logic [XW-1:0] x0_q;
    logic [YW-1:0] y0_q;
    logic [AW-1:0] base_q;
    logic [NW-1:0] rows_q;
    logic [NW-1:0] row_q;
    logic [BW-1:0] bit_q;

    // Command operands: captured when a draw is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x0_q   <= '0;
            y0_q   <= '0;
            base_q <= '0;
            rows_q <= '0;
        end else if (start) begin
            x0_q   <= org_x;
            y0_q   <= org_y;
            base_q <= base;
            rows_q <= rows;
        end
    end

    // Row/bit position: bit counts across a row, then the row advances.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            row_q <= '0;
            bit_q <= '0;
        end else if (adv) begin
            if (bit_last) begin
                bit_q <= '0;
                row_q <= row_q + 1'b1;
            end else begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    assign bit_last = (bit_q == BW'(DW - 1));
    assign row_last = (row_q == rows_q - NW'(1));
    assign bit_idx  = bit_q;
    assign px_x     = x0_q + XW'(bit_q);
    assign px_y     = y0_q + YW'(row_q);
    assign row_addr = base_q + AW'(row_q);

endmodule

// File: rtl/fbb_xor_unit.sv
// Pixel combiner: holds the current sprite row byte, selects the sprite bit
// (MSB is leftmost), forms the XOR write value and keeps the collision flag.
// Assumes: row_load only while the memory read data is valid; wr_en only
// while old_bit carries the framebuffer read data.
module fbb_xor_unit #(
    parameter int DW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hit_clr,
    input  logic                   row_load,
    input  logic [DW-1:0]          row_in,
    input  logic [$clog2(DW)-1:0]  bit_idx,
    input  logic                   wr_en,
    input  logic                   old_bit,
    output logic                   new_bit,
    output logic                   hit
);
    localparam int BW = $clog2(DW);

    logic [DW-1:0] row_q;
    logic          spr_bit;
    logic          hit_q;

    // Sprite row byte: loaded at the first pixel of each row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (row_load) begin
            row_q <= row_in;
        end
    end

    assign spr_bit = row_q[BW'(DW - 1) - bit_idx];
    assign new_bit = old_bit ^ spr_bit;

    // Collision flag: cleared per draw, set by any lit pixel being erased.
    always_ff @(posedge clk) begin
        if (!rst_n || hit_clr) begin
            hit_q <= 1'b0;
        end else if (wr_en && old_bit && spr_bit) begin
            hit_q <= 1'b1;
        end
    end

    assign hit = hit_q;

    p_erase_sets_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && old_bit && !new_bit && !hit_clr) |=> hit);

endmodule

// File: rtl/fb_blit_engine.sv
// Framebuffer clear and sprite blitter top. Sequences one-pixel-per-cycle
// clears and read-then-write XOR sprite draws against an external
// bit-addressed framebuffer and a byte-addressed memory, both with a
// one-cycle synchronous read.
// Assumes: requests are only honoured in idle; clear has priority.
module fb_blit_engine
    import fbb_pkg::*;
#(
    parameter int XW = 6,
    parameter int YW = 5,
    parameter int AW = 12,
    parameter int NW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_req,
    input  logic          drw_req,
    input  logic [XW-1:0] drw_x,
    input  logic [YW-1:0] drw_y,
    input  logic [NW-1:0] drw_rows,
    input  logic [AW-1:0] drw_base,
    output logic          busy,
    output logic          done,
    output logic          hit,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    input  logic [DW-1:0] mem_data,
    output logic [XW-1:0] fb_x,
    output logic [YW-1:0] fb_y,
    output logic          fb_rd,
    output logic          fb_we,
    output logic          fb_wdata,
    input  logic          fb_rdata
);
    localparam int BW = $clog2(DW);

    fbb_state_e state_q, state_d;

    logic          clr_take, drw_take;
    logic          scan_step, scan_last;
    logic [XW-1:0] scan_x, px_x;
    logic [YW-1:0] scan_y, px_y;
    logic          walk_adv, bit_last, row_last;
    logic [BW-1:0] bit_idx;
    logic          new_bit;

    assign clr_take  = (state_q == ST_IDLE) && clr_req;
    assign drw_take  = (state_q == ST_IDLE) && drw_req && !clr_req;
    assign scan_step = (state_q == ST_CLR);
    assign walk_adv  = (state_q == ST_WRITE);

    // Next-state selection for clear sweep and per-pixel draw phases.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (clr_take) begin
                    state_d = ST_CLR;
                end else if (drw_take) begin
                    state_d = (drw_rows == '0) ? ST_DONE : ST_FETCH;
                end
            end
            ST_CLR:   state_d = scan_last ? ST_DONE : ST_CLR;
            ST_FETCH: state_d = ST_READ;
            ST_READ:  state_d = ST_WRITE;
            ST_WRITE: begin
                if (!bit_last) begin
                    state_d = ST_READ;
                end else begin
                    state_d = row_last ? ST_DONE : ST_FETCH;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    fbb_clear_scan #(.XW(XW), .YW(YW)) u_scan (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (clr_take),
        .step   (scan_step),
        .scan_x (scan_x),
        .scan_y (scan_y),
        .last   (scan_last)
    );

    fbb_sprite_walk #(.XW(XW), .YW(YW), .AW(AW), .NW(NW), .DW(DW)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (drw_take),
        .adv      (walk_adv),
        .org_x    (drw_x),
        .org_y    (drw_y),
        .base     (drw_base),
        .rows     (drw_rows),
        .px_x     (px_x),
        .px_y     (px_y),
        .row_addr (mem_addr),
        .bit_idx  (bit_idx),
        .bit_last (bit_last),
        .row_last (row_last)
    );

    fbb_xor_unit #(.DW(DW)) u_xor (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_clr  (drw_take),
        .row_load ((state_q == ST_READ) && (bit_idx == '0)),
        .row_in   (mem_data),
        .bit_idx  (bit_idx),
        .wr_en    (walk_adv),
        .old_bit  (fb_rdata),
        .new_bit  (new_bit),
        .hit      (hit)
    );

    // Port drive: address mux between sweep and sprite, strobes per phase.
    always_comb begin
        busy     = (state_q != ST_IDLE) && (state_q != ST_DONE);
        done     = (state_q == ST_DONE);
        mem_rd   = (state_q == ST_FETCH);
        fb_rd    = (state_q == ST_READ);
        fb_we    = (state_q == ST_CLR) || (state_q == ST_WRITE);
        fb_wdata = (state_q == ST_WRITE) ? new_bit : 1'b0;
        fb_x     = (state_q == ST_CLR) ? scan_x : px_x;
        fb_y     = (state_q == ST_CLR) ? scan_y : px_y;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!fb_we && !fb_rd && !mem_rd));

    p_unread_write_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_we && !$past(fb_rd)) |-> !fb_wdata);

    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_not_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_fetch_leads_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (fb_rd && !fb_we));

    p_read_then_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fb_rd |=> (fb_we && fb_x == $past(fb_x) && fb_y == $past(fb_y)));

    p_hit_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hit) |-> $past(drw_take));

endmodule

// File: tb/fb_blit_engine_test.sv
`timescale 1ns/1ps
module fb_blit_engine_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        clr_req, drw_req;
    logic [5:0]  drw_x;
    logic [4:0]  drw_y;
    logic [3:0]  drw_rows;
    logic [11:0] drw_base;
    logic        busy, done, hit;
    logic [11:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_data;
    logic [5:0]  fb_x;
    logic [4:0]  fb_y;
    logic        fb_rd, fb_we, fb_wdata, fb_rdata;

    always #4 clk = ~clk;

    fb_blit_engine uut (
        .clk(clk), .rst_n(rst_n), .clr_req(clr_req), .drw_req(drw_req),
        .drw_x(drw_x), .drw_y(drw_y), .drw_rows(drw_rows), .drw_base(drw_base),
        .busy(busy), .done(done), .hit(hit),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_data(mem_data),
        .fb_x(fb_x), .fb_y(fb_y), .fb_rd(fb_rd), .fb_we(fb_we),
        .fb_wdata(fb_wdata), .fb_rdata(fb_rdata)
    );

    // Memory and framebuffer models, plus access-order trackers.
    logic [7:0] mem [0:4095];
    logic       fbm [0:2047];
    int  n_chk = 0, n_bad = 0;
    int  ord_err, pair_err, fb_acc, clr_idx;
    bit  trk_clr = 0, trk_drw = 0;
    logic        prev_rd = 1'b0;
    logic [10:0] prev_a = '0;

    always @(posedge clk) begin
        if (mem_rd) mem_data <= mem[mem_addr];
        if (fb_rd)  fb_rdata <= fbm[{fb_x, fb_y}];
        if (fb_rd || fb_we) fb_acc = fb_acc + 1;
        if (fb_we) begin
            fbm[{fb_x, fb_y}] <= fb_wdata;
            if (trk_clr) begin
                if ({fb_x, fb_y} != 11'(clr_idx) || fb_wdata) ord_err = ord_err + 1;
                clr_idx = clr_idx + 1;
            end
            if (trk_drw && (!prev_rd || prev_a != {fb_x, fb_y})) pair_err = pair_err + 1;
        end
        prev_rd <= fb_rd;
        prev_a  <= {fb_x, fb_y};
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Issue a command, optionally inject a request mid-command, wait for done.
    task automatic run_cmd(input logic c, input logic d, input int inj_at,
                           input logic ic, input logic id,
                           output int cyc, output int nb);
        @(negedge clk);
        clr_req = c; drw_req = d; cyc = 0; nb = 0;
        do begin
            @(posedge clk); @(negedge clk);
            clr_req = 1'b0; drw_req = 1'b0;
            cyc++;
            if (busy) nb++;
            if (cyc == inj_at) begin clr_req = ic; drw_req = id; end
        end while (!done && cyc < 5000);
    endtask

    task automatic do_clear(input logic d_too, input int inj_at,
                            input logic ic, input logic id, input string req);
        int cyc, nb, z;
        for (int i = 0; i < 2048; i++) fbm[i] = 1'b1;
        clr_idx = 0; ord_err = 0; trk_clr = 1;
        run_cmd(1'b1, d_too, inj_at, ic, id, cyc, nb);
        trk_clr = 0;
        z = 0;
        for (int i = 0; i < 2048; i++) if (fbm[i] == 1'b0) z++;
        check(cyc == 2049, req, "clear done cycle", cyc, 2049);
        check(nb == 2048, req, "clear busy cycles", nb, 2048);
        check(ord_err == 0, req, "clear write order errors", ord_err, 0);
        check(z == 2048, req, "cleared pixel count", z, 2048);
    endtask

    task automatic do_draw(input int x, input int y, input int n, input int base,
                           input int inj_at, input logic ic, input logic id,
                           input string req);
        logic ef [0:2047];
        logic eh;
        int cyc, nb, mm;
        logic [7:0] rb;
        logic [10:0] a;
        for (int i = 0; i < 2048; i++) ef[i] = fbm[i];
        eh = 1'b0;
        for (int r = 0; r < n; r++) begin
            rb = mem[(base + r) % 4096];
            for (int b = 0; b < 8; b++) begin
                a = {6'((x + b) % 64), 5'((y + r) % 32)};
                if (ef[a] && rb[7 - b]) eh = 1'b1;
                ef[a] = ef[a] ^ rb[7 - b];
            end
        end
        drw_x = 6'(x); drw_y = 5'(y); drw_rows = 4'(n); drw_base = 12'(base);
        pair_err = 0; fb_acc = 0; trk_drw = 1;
        run_cmd(1'b0, 1'b1, inj_at, ic, id, cyc, nb);
        trk_drw = 0;
        mm = 0;
        for (int i = 0; i < 2048; i++) if (fbm[i] !== ef[i]) mm++;
        check(mm == 0, {req, " R4"}, "wrong pixels", mm, 0);
        check(hit == eh, {req, " R6"}, "collision flag", int'(hit), int'(eh));
        check(cyc == 17 * n + 1, {req, " R5"}, "draw done cycle", cyc, 17 * n + 1);
        check(nb == 17 * n, {req, " R5"}, "draw busy cycles", nb, 17 * n);
        check(pair_err == 0, {req, " R5"}, "read/write pairing errors", pair_err, 0);
        if (n == 0) check(fb_acc == 0, "R7", "framebuffer accesses", fb_acc, 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; clr_req = 0; drw_req = 0;
        drw_x = '0; drw_y = '0; drw_rows = '0; drw_base = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check(!busy && !done && !hit, "R1", "busy/done/hit after reset",
              int'({busy, done, hit}), 0);
        check(!fb_we && !fb_rd && !mem_rd, "R1", "strobes after reset",
              int'({fb_we, fb_rd, mem_rd}), 0);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 29 + (i >> 4) + 7);
        for (int i = 0; i < 2048; i++) fbm[i] = 1'b0;
        mem_data = '0; fb_rdata = 1'b0;
        ord_err = 0; pair_err = 0; fb_acc = 0; clr_idx = 0;
        t_reset();
        do_clear(1'b0, 0, 1'b0, 1'b0, "R2 R3");
        do_draw(10, 5, 5, 12'h200, 0, 1'b0, 1'b0, "blank");
        do_draw(10, 5, 5, 12'h200, 0, 1'b0, 1'b0, "redraw");
        check(hit == 1'b1, "R6", "erasing redraw sets hit", int'(hit), 1);
        do_clear(1'b0, 0, 1'b0, 1'b0, "R2");
        check(hit == 1'b1, "R6", "hit kept across clear", int'(hit), 1);
        do_draw(0, 0, 0, 12'h000, 0, 1'b0, 1'b0, "R7");
        check(hit == 1'b0, "R7", "empty draw clears hit", int'(hit), 0);
        do_draw(60, 30, 4, 12'hFFE, 0, 1'b0, 1'b0, "wrap");
        do_draw(62, 31, 15, 12'h7F0, 0, 1'b0, 1'b0, "overlap");
        do_clear(1'b0, 100, 1'b0, 1'b1, "R8");
        do_clear(1'b0, 500, 1'b1, 1'b0, "R8");
        do_draw(3, 7, 6, 12'h123, 3, 1'b1, 1'b0, "R8");
        do_draw(40, 20, 2, 12'h456, 20, 1'b0, 1'b1, "R8");
        do_clear(1'b1, 0, 1'b0, 1'b0, "R9");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule